// File: doc/BRIEF.md
# Cache Maintenance Sequencer

This block carries out maintenance operations that software requests on a small set-associative write-back cache. A flush walks every line of the cache in a fixed order. For each line that holds modified data, it reads the data word and writes it back to the backing memory. After each good write it marks the line clean. When the walk ends, it reports whether every write-back succeeded. An invalidate clears the valid and dirty state of every line and writes nothing back.

Software starts an operation by setting a request bit. The bit stays set while the operation is pending or running, and the hardware clears it when the operation completes. A status word reports completion and failure. If the backing memory answers a write with a bus error, the block captures the address of that write for software to inspect. The walker's current state is readable as a small code, so a debugger can see where a long flush has stalled.

The tag and data storage sits outside the block. The sequencer drives a read port and a state-write port for the tags and a read port for the data. It sends one write-back at a time to the backing memory and waits for the completion response.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, the request word (offset 0xC0), the status word (0xC4), the error address (0x48) and the state code (0x4C) all read zero.
- R2: A register write to 0xC0 with bit 31 set requests a flush, and one with bit 30 set requests an invalidate. Writing 0 to either bit has no effect. Each request bit reads back as 1 until its operation finishes, then clears itself.
- R3: A flush visits sets in ascending order and ways in ascending order within each set. It writes back exactly the lines that are both valid and dirty, one at a time. Each write-back address is {tag, set index, zero line offset} and its data is the line's data word. Address and data stay stable until the backing memory reports done.
- R4: A write-back that completes without error clears that line's dirty bit and leaves it valid. A write-back that returns an error leaves the line dirty.
- R5: A flush continues past failed write-backs to the last line. It then sets status bit 31 (flush done), and sets status bit 29 (flush failed) only if at least one write-back returned an error.
- R6: A write to 0xC0 with bit 31 set clears status bits 31, 30 and 29 at once. A write with only bit 30 set clears status bit 30 only.
- R7: An invalidate clears the valid and dirty bits of every line, issues no write-back, and sets status bit 30 (invalidate done) when it finishes.
- R8: When a flush and an invalidate are both pending, the flush runs to completion before the invalidate begins.
- R9: The address of the first write-back that returns an error is captured at 0x48. Later errors do not overwrite it. Writing zero to 0x48 clears it and arms it for the next error, and a nonzero write to 0x48 is ignored.
- R10: Bits 4:0 of 0x4C give the state code: 0 idle, 13 tag read, 14 way selection, 12 data read, 15 waiting on a write-back, 17 invalidate walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register, same cycle |
| tag_rd_en | output | 1 | Tag/state read of all ways of `line_set` |
| line_set | output | SET_W | Set index for tag read, state write and data read |
| tag_valid | input | WAYS | Valid bits of the last set read, held until the next read |
| tag_dirty | input | WAYS | Dirty bits of the last set read, held until the next read |
| tag_tags | input | WAYS*TAG_W | Tags of the last set read, way 0 in the low bits |
| tag_we | output | WAYS | Per-way state-write enable |
| tag_wvalid | output | 1 | Valid value written to enabled ways |
| tag_wdirty | output | 1 | Dirty value written to enabled ways |
| dat_rd_en | output | 1 | Data read of one line |
| dat_way | output | WAY_W | Way index of the data read |
| dat_rdata | input | DATA_W | Data word, valid the cycle after the read, held until the next |
| bw_req | output | 1 | Write-back request, held until done |
| bw_addr | output | 32 | Write-back byte address |
| bw_data | output | DATA_W | Write-back data |
| bw_done | input | 1 | Backing write completed (one cycle) |
| bw_err | input | 1 | Bus error, qualified by `bw_done` |

## Verification
The hardest case to reach from the ports is a flush in which several write-backs fail. The block must go on walking after each failure, keep only the first failing address, keep the failed lines dirty, and report failure only at the very end. The bench's backing-memory responder marks chosen lines as failing and varies its response latency. A scoreboard queue holds the expected write-backs in walk order, so every surviving write, its data and its position are checked. A combined flush-and-invalidate request and an invalidate issued over a fully dirty cache cover the ordering cases and the no-write-back case.

// File: rtl/cmseq_pkg.sv
// Package: shared state codes and register offsets of the maintenance sequencer.
// Assumes byte offsets on an 8-bit register address.
package cmseq_pkg;

    typedef enum logic [4:0] {
        ST_IDLE    = 5'd0,
        ST_FL_DATA = 5'd12,
        ST_TAG_RD  = 5'd13,
        ST_PICK    = 5'd14,
        ST_WB      = 5'd15,
        ST_INV     = 5'd17
    } seq_state_e;

    localparam logic [7:0] OFS_ERRADDR = 8'h48;
    localparam logic [7:0] OFS_STATE   = 8'h4C;
    localparam logic [7:0] OFS_REQ     = 8'hC0;
    localparam logic [7:0] OFS_STAT    = 8'hC4;

    localparam int BIT_FLUSH   = 31;
    localparam int BIT_INV     = 30;
    localparam int BIT_FAIL    = 29;

endpackage

// File: rtl/cmseq_pick.sv
// Way picker: finds the lowest way at or above a start pointer that is both valid
// and dirty. Assumes start may equal WAYS, meaning nothing is left in the set.
module cmseq_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int PTR_W = WAY_W + 1
) (
    input  logic [WAYS-1:0]  valid,
    input  logic [WAYS-1:0]  dirty,
    input  logic [PTR_W-1:0] start,
    output logic             hit,
    output logic [WAY_W-1:0] idx
);

    logic [WAYS-1:0] cand;

    // Candidate mask: a modified line at or beyond the start pointer.
    for (genvar gi = 0; gi < WAYS; gi++) begin : g_cand
        assign cand[gi] = valid[gi] & dirty[gi] & (PTR_W'(gi) >= start);
    end

    // Priority encoder, lowest way wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit = 1'b1;
                idx = WAY_W'(i);
            end
        end
    end

endmodule

// File: rtl/cmseq_walk.sv
// Walker: steps through sets and ways for a flush and through sets for an
// invalidate. Assumes the tag and data stores return read data one cycle after
// the read and hold it until the next read.
module cmseq_walk
    import cmseq_pkg::*;
#(
    parameter int SETS    = 8,
    parameter int WAYS    = 4,
    parameter int DATA_W  = 32,
    parameter int LINE_OW = 4,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int PTR_W  = WAY_W + 1,
    localparam int TAG_W  = 32 - SET_W - LINE_OW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush_pend,
    input  logic                  inv_pend,
    output seq_state_e            state,
    output logic                  tag_rd_en,
    output logic [SET_W-1:0]      line_set,
    input  logic [WAYS-1:0]       tag_valid,
    input  logic [WAYS-1:0]       tag_dirty,
    input  logic [WAYS*TAG_W-1:0] tag_tags,
    output logic [WAYS-1:0]       tag_we,
    output logic                  tag_wvalid,
    output logic                  tag_wdirty,
    output logic                  dat_rd_en,
    output logic [WAY_W-1:0]      dat_way,
    input  logic [DATA_W-1:0]     dat_rdata,
    output logic                  bw_req,
    output logic [31:0]           bw_addr,
    output logic [DATA_W-1:0]     bw_data,
    input  logic                  bw_done,
    input  logic                  bw_err,
    output logic                  flush_fin,
    output logic                  flush_fail,
    output logic                  inv_fin,
    output logic                  err_pulse,
    output logic [31:0]           err_addr
);

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

    seq_state_e       state_q;
    logic [SET_W-1:0] set_q;
    logic [PTR_W-1:0] ptr_q;
    logic [WAY_W-1:0] sel_q;
    logic             err_seen_q;
    logic             hit;
    logic [WAY_W-1:0] hit_idx;
    logic [TAG_W-1:0] sel_tag;

    cmseq_pick #(.WAYS(WAYS)) u_pick (
        .valid (tag_valid),
        .dirty (tag_dirty),
        .start (ptr_q),
        .hit   (hit),
        .idx   (hit_idx)
    );

    // Tag of the selected way and the write-back address built from it.
    assign sel_tag    = tag_tags[sel_q*TAG_W +: TAG_W];
    assign bw_addr    = {sel_tag, set_q, {LINE_OW{1'b0}}};
    assign bw_data    = dat_rdata;
    assign line_set   = set_q;
    assign dat_way    = sel_q;
    assign state      = state_q;
    assign flush_fail = err_seen_q;
    assign err_addr   = bw_addr;

    // Per-state strobes towards the stores, the backing port and the registers.
    always_comb begin
        tag_rd_en  = 1'b0;
        dat_rd_en  = 1'b0;
        bw_req     = 1'b0;
        tag_we     = '0;
        tag_wvalid = 1'b0;
        tag_wdirty = 1'b0;
        flush_fin  = 1'b0;
        inv_fin    = 1'b0;
        err_pulse  = 1'b0;
        case (state_q)
            ST_TAG_RD:  tag_rd_en = 1'b1;
            ST_FL_DATA: dat_rd_en = 1'b1;
            ST_PICK:    flush_fin = !hit && (set_q == LAST_SET);
            ST_WB: begin
                bw_req     = 1'b1;
                tag_wvalid = 1'b1;
                if (bw_done && !bw_err) tag_we = WAYS'(1) << sel_q;
                err_pulse  = bw_done && bw_err;
            end
            ST_INV: begin
                tag_we  = '1;
                inv_fin = (set_q == LAST_SET);
            end
            default: ;
        endcase
    end

    // Sequencing of the walk; the flush is taken before a pending invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            set_q      <= '0;
            ptr_q      <= '0;
            sel_q      <= '0;
            err_seen_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    set_q <= '0;
                    if (flush_pend) begin
                        err_seen_q <= 1'b0;
                        state_q    <= ST_TAG_RD;
                    end else if (inv_pend) begin
                        state_q <= ST_INV;
                    end
                end
                ST_TAG_RD: begin
                    ptr_q   <= '0;
                    state_q <= ST_PICK;
                end
                ST_PICK: begin
                    if (hit) begin
                        sel_q   <= hit_idx;
                        state_q <= ST_FL_DATA;
                    end else if (set_q == LAST_SET) begin
                        set_q   <= '0;
                        state_q <= inv_pend ? ST_INV : ST_IDLE;
                    end else begin
                        set_q   <= set_q + 1'b1;
                        state_q <= ST_TAG_RD;
                    end
                end
                ST_FL_DATA: state_q <= ST_WB;
                ST_WB: begin
                    if (bw_done) begin
                        if (bw_err) err_seen_q <= 1'b1;
                        ptr_q   <= PTR_W'(sel_q) + 1'b1;
                        state_q <= ST_PICK;
                    end
                end
                ST_INV: begin
                    if (set_q == LAST_SET) begin
                        set_q   <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        set_q <= set_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: an outstanding write-back keeps its address and data until done.
    p_wb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bw_req && !bw_done |=> bw_req && $stable(bw_addr) && $stable(bw_data));

    // R4: outside an invalidate, a state write follows only a clean completion.
    p_clean_after_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we != '0) && (state_q != ST_INV) |-> bw_done && !bw_err && $onehot0(tag_we));

    // R8: with both pending in idle, the flush walk begins first.
    p_flush_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && flush_pend |=> (state_q == ST_TAG_RD));

    // R5: a failure recorded in a walk survives until that walk reports.
    p_fail_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> err_seen_q);

endmodule

// File: rtl/cmseq_regs.sv
// Register file: request bits, completion status and the error-address capture.
// Assumes one write per cycle and a combinational read of the addressed word.
module cmseq_regs
    import cmseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  seq_state_e  state,
    input  logic        flush_fin,
    input  logic        flush_fail,
    input  logic        inv_fin,
    input  logic        err_pulse,
    input  logic [31:0] err_addr,
    output logic        flush_pend,
    output logic        inv_pend
);

    logic        flush_req_q;
    logic        inv_req_q;
    logic        flush_done_q;
    logic        flush_fail_q;
    logic        inv_done_q;
    logic        held_q;
    logic [31:0] latch_q;
    logic        wr_req;
    logic        set_flush;
    logic        set_inv;
    logic        clr_latch;

    assign wr_req    = reg_wr && (reg_addr == OFS_REQ);
    assign set_flush = wr_req && reg_wdata[BIT_FLUSH];
    assign set_inv   = wr_req && reg_wdata[BIT_INV];
    assign clr_latch = reg_wr && (reg_addr == OFS_ERRADDR) && (reg_wdata == 32'd0);
    assign flush_pend = flush_req_q;
    assign inv_pend   = inv_req_q;

    // Request bits: set by software, cleared by the matching completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_req_q <= 1'b0;
            inv_req_q   <= 1'b0;
        end else begin
            if (set_flush)      flush_req_q <= 1'b1;
            else if (flush_fin) flush_req_q <= 1'b0;
            if (set_inv)        inv_req_q <= 1'b1;
            else if (inv_fin)   inv_req_q <= 1'b0;
        end
    end

    // Status bits: cleared by a new request, set by completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_done_q <= 1'b0;
            flush_fail_q <= 1'b0;
            inv_done_q   <= 1'b0;
        end else begin
            if (set_flush) begin
                flush_done_q <= 1'b0;
                flush_fail_q <= 1'b0;
            end else if (flush_fin) begin
                flush_done_q <= 1'b1;
                flush_fail_q <= flush_fail;
            end
            if (set_flush || set_inv) inv_done_q <= 1'b0;
            else if (inv_fin)         inv_done_q <= 1'b1;
        end
    end

    // Error address: first error captured, held until software writes zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= 1'b0;
            latch_q <= '0;
        end else if (err_pulse && (!held_q || clr_latch)) begin
            held_q  <= 1'b1;
            latch_q <= err_addr;
        end else if (clr_latch) begin
            held_q  <= 1'b0;
            latch_q <= '0;
        end
    end

    // Read mux over the four visible words.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_ERRADDR: reg_rdata = latch_q;
            OFS_STATE:   reg_rdata[4:0] = state;
            OFS_REQ: begin
                reg_rdata[BIT_FLUSH] = flush_req_q;
                reg_rdata[BIT_INV]   = inv_req_q;
            end
            OFS_STAT: begin
                reg_rdata[BIT_FLUSH] = flush_done_q;
                reg_rdata[BIT_INV]   = inv_done_q;
                reg_rdata[BIT_FAIL]  = flush_fail_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R9: a captured address is not replaced until software clears it.
    p_first_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        held_q && !clr_latch |=> held_q && $stable(latch_q));

    // R2: flush done appears only as its request bit drops.
    p_done_with_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_done_q) |-> $fell(flush_req_q));

    // R5: a failed flag is never shown without the done flag.
    p_fail_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fail_q |-> flush_done_q);

    // R6: a flush request write empties the status word on the next cycle.
    p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_flush |=> !flush_done_q && !flush_fail_q && !inv_done_q);

endmodule

// File: rtl/cache_maint_seq.sv
// Top of the cache maintenance sequencer: joins the register file and the walker.
// Assumes external tag/data stores with one-cycle held read data and a backing
// write port answering each request with a single-cycle done.
module cache_maint_seq
    import cmseq_pkg::*;
#(
    parameter int SETS    = 8,
    parameter int WAYS    = 4,
    parameter int DATA_W  = 32,
    parameter int LINE_OW = 4,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int TAG_W  = 32 - SET_W - LINE_OW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic                  tag_rd_en,
    output logic [SET_W-1:0]      line_set,
    input  logic [WAYS-1:0]       tag_valid,
    input  logic [WAYS-1:0]       tag_dirty,
    input  logic [WAYS*TAG_W-1:0] tag_tags,
    output logic [WAYS-1:0]       tag_we,
    output logic                  tag_wvalid,
    output logic                  tag_wdirty,
    output logic                  dat_rd_en,
    output logic [WAY_W-1:0]      dat_way,
    input  logic [DATA_W-1:0]     dat_rdata,
    output logic                  bw_req,
    output logic [31:0]           bw_addr,
    output logic [DATA_W-1:0]     bw_data,
    input  logic                  bw_done,
    input  logic                  bw_err
);

    seq_state_e  state;
    logic        flush_pend;
    logic        inv_pend;
    logic        flush_fin;
    logic        flush_fail;
    logic        inv_fin;
    logic        err_pulse;
    logic [31:0] err_addr;

    cmseq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .state      (state),
        .flush_fin  (flush_fin),
        .flush_fail (flush_fail),
        .inv_fin    (inv_fin),
        .err_pulse  (err_pulse),
        .err_addr   (err_addr),
        .flush_pend (flush_pend),
        .inv_pend   (inv_pend)
    );

    cmseq_walk #(
        .SETS    (SETS),
        .WAYS    (WAYS),
        .DATA_W  (DATA_W),
        .LINE_OW (LINE_OW)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_pend (flush_pend),
        .inv_pend   (inv_pend),
        .state      (state),
        .tag_rd_en  (tag_rd_en),
        .line_set   (line_set),
        .tag_valid  (tag_valid),
        .tag_dirty  (tag_dirty),
        .tag_tags   (tag_tags),
        .tag_we     (tag_we),
        .tag_wvalid (tag_wvalid),
        .tag_wdirty (tag_wdirty),
        .dat_rd_en  (dat_rd_en),
        .dat_way    (dat_way),
        .dat_rdata  (dat_rdata),
        .bw_req     (bw_req),
        .bw_addr    (bw_addr),
        .bw_data    (bw_data),
        .bw_done    (bw_done),
        .bw_err     (bw_err),
        .flush_fin  (flush_fin),
        .flush_fail (flush_fail),
        .inv_fin    (inv_fin),
        .err_pulse  (err_pulse),
        .err_addr   (err_addr)
    );

    // R10: the state code in idle never coexists with store or backing activity.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !bw_req && !tag_rd_en && !dat_rd_en && (tag_we == '0));

endmodule

// File: tb/cache_maint_seq_tb.sv
// Scoreboard bench: a driver fills the modelled cache and pushes the expected
// write-backs; the responder process pops and compares them as they appear.
module cache_maint_seq_tb;

    localparam int SETS = 8;
    localparam int WAYS = 4;
    localparam int DW   = 32;
    localparam int OW   = 4;
    localparam int SW   = 3;
    localparam int WW   = 2;
    localparam int TW   = 32 - SW - OW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [7:0]      reg_addr = 8'h4C;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            tag_rd_en;
    logic [SW-1:0]   line_set;
    logic [WAYS-1:0] tag_valid = '0;
    logic [WAYS-1:0] tag_dirty = '0;
    logic [WAYS*TW-1:0] tag_tags = '0;
    logic [WAYS-1:0] tag_we;
    logic            tag_wvalid, tag_wdirty, dat_rd_en;
    logic [WW-1:0]   dat_way;
    logic [DW-1:0]   dat_rdata = '0;
    logic            bw_req;
    logic [31:0]     bw_addr;
    logic [DW-1:0]   bw_data;
    logic            bw_done = 1'b0;
    logic            bw_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int lat = 1;
    bit inv_seen = 0;

    logic          m_valid [SETS][WAYS];
    logic          m_dirty [SETS][WAYS];
    logic [TW-1:0] m_tag   [SETS][WAYS];
    logic [DW-1:0] m_data  [SETS][WAYS];
    logic          m_err   [SETS][WAYS];

    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    logic        exp_err  [$];

    cache_maint_seq #(.SETS(SETS), .WAYS(WAYS), .DATA_W(DW), .LINE_OW(OW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tag_rd_en(tag_rd_en),
        .line_set(line_set), .tag_valid(tag_valid), .tag_dirty(tag_dirty),
        .tag_tags(tag_tags), .tag_we(tag_we), .tag_wvalid(tag_wvalid),
        .tag_wdirty(tag_wdirty), .dat_rd_en(dat_rd_en), .dat_way(dat_way),
        .dat_rdata(dat_rdata), .bw_req(bw_req), .bw_addr(bw_addr),
        .bw_data(bw_data), .bw_done(bw_done), .bw_err(bw_err)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Store model: held read outputs and state writes at the clock edge.
    initial forever begin
        @(posedge clk);
        if (tag_rd_en) begin
            for (int w = 0; w < WAYS; w++) begin
                tag_valid[w] <= m_valid[line_set][w];
                tag_dirty[w] <= m_dirty[line_set][w];
                tag_tags[w*TW +: TW] <= m_tag[line_set][w];
            end
        end
        if (dat_rd_en) dat_rdata <= m_data[line_set][dat_way];
        for (int w = 0; w < WAYS; w++) begin
            if (tag_we[w]) begin
                m_valid[line_set][w] <= tag_wvalid;
                m_dirty[line_set][w] <= tag_wdirty;
            end
        end
    end

    // Monitor and backing responder: state-code checks, scoreboard pops.
    initial forever begin
        @(negedge clk);
        bw_done = 1'b0;
        bw_err  = 1'b0;
        if (rst_n && !reg_wr && reg_addr == 8'h4C) begin
            if (bw_req)    check(reg_rdata[4:0] == 5'd15, "R10 wb code", reg_rdata, 15);
            if (tag_rd_en) check(reg_rdata[4:0] == 5'd13, "R10 tag code", reg_rdata, 13);
            if (dat_rd_en) check(reg_rdata[4:0] == 5'd12, "R10 data code", reg_rdata, 12);
            if (reg_rdata[4:0] == 5'd17) begin
                if (!inv_seen) begin
                    check(tag_we == '1, "R10 inv code", {28'd0, tag_we}, 32'hF);
                    check(exp_addr.size() == 0, "R8 inv after flush", exp_addr.size(), 0);
                end
                inv_seen = 1;
            end
        end
        if (bw_req) begin
            lat_cnt++;
            if (lat_cnt >= lat) begin
                lat_cnt = 0;
                if (exp_addr.size() == 0) begin
                    check(0, "R3/R7 unexpected write-back", bw_addr, 0);
                    bw_done = 1'b1;
                end else begin
                    logic [31:0] ea, ed;
                    logic ee;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    ee = exp_err.pop_front();
                    check(bw_addr == ea, "R3 wb address", bw_addr, ea);
                    check(bw_data == ed, "R3 wb data", bw_data, ed);
                    bw_done = 1'b1;
                    bw_err  = ee;
                end
            end
        end
    end

    int lat_cnt = 0;

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'h4C; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata; #1;
        reg_addr = 8'h4C;
    endtask

    task automatic fill(input int seed, input bit dirty_on);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = ((s * WAYS + w + seed) % 3) != 0;
                m_dirty[s][w] = dirty_on && m_valid[s][w] && (((s + w + seed) % 2) == 0);
                m_tag[s][w]   = TW'(32'h1000 + seed * 256 + s * 16 + w);
                m_data[s][w]  = 32'hA500_0000 ^ (seed << 16) ^ (s << 8) ^ w;
                m_err[s][w]   = 1'b0;
            end
    endtask

    // Expected write-backs in walk order, one entry per modified line.
    task automatic push_expected(output int nerr, output logic [31:0] first_bad);
        nerr = 0;
        first_bad = '0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
                if (m_valid[s][w] && m_dirty[s][w]) begin
                    logic [31:0] a;
                    a = {m_tag[s][w], SW'(s), {OW{1'b0}}};
                    exp_addr.push_back(a);
                    exp_data.push_back(m_data[s][w]);
                    exp_err.push_back(m_err[s][w]);
                    if (m_err[s][w]) begin
                        if (nerr == 0) first_bad = a;
                        nerr++;
                    end
                end
    endtask

    task automatic wait_clear(input logic [31:0] mask, input string req);
        logic [31:0] v;
        for (int i = 0; i < 4000; i++) begin
            reg_read(8'hC0, v);
            if ((v & mask) == 0) begin
                check(1, req, v, 0);
                return;
            end
        end
        check(0, {req, " request never cleared"}, v, 0);
    endtask

    task automatic run_flush(input string tag, input bit expect_fail);
        int nerr;
        logic [31:0] fb, v;
        bit snap_v [SETS][WAYS];
        bit snap_d [SETS][WAYS];
        bit snap_e [SETS][WAYS];
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                snap_v[s][w] = m_valid[s][w];
                snap_d[s][w] = m_dirty[s][w];
                snap_e[s][w] = m_err[s][w];
            end
        push_expected(nerr, fb);
        reg_write(8'hC0, 32'h8000_0000);
        wait_clear(32'h8000_0000, {"R2 flush ", tag});
        check(exp_addr.size() == 0, {"R3 all written ", tag}, exp_addr.size(), 0);
        reg_read(8'hC4, v);
        check(v == (expect_fail ? 32'hA000_0000 : 32'h8000_0000),
              {"R5 status ", tag}, v, expect_fail ? 32'hA000_0000 : 32'h8000_0000);
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                bit ed;
                ed = snap_d[s][w] && snap_e[s][w];
                if (m_dirty[s][w] !== ed || m_valid[s][w] !== snap_v[s][w])
                    check(0, {"R4 line state ", tag}, {m_valid[s][w], m_dirty[s][w]},
                          {snap_v[s][w], ed});
            end
        check(1, {"R4 line walk ", tag}, 0, 0);
    endtask

    logic [31:0] rv;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset values
        reg_read(8'hC0, rv); check(rv == 0, "R1 request", rv, 0);
        reg_read(8'hC4, rv); check(rv == 0, "R1 status", rv, 0);
        reg_read(8'h48, rv); check(rv == 0, "R1 error address", rv, 0);
        reg_read(8'h4C, rv); check(rv == 0, "R1 state", rv, 0);

        // R2 writing zero requests nothing
        fill(1, 1);
        reg_write(8'hC0, 32'h0);
        repeat (4) @(posedge clk);
        reg_read(8'hC0, rv); check(rv == 0, "R2 zero write", rv, 0);
        reg_read(8'h4C, rv); check(rv == 0, "R2 stays idle", rv, 0);

        // R3/R4/R5 clean flush, latency 1
        lat = 1;
        run_flush("clean", 0);

        // R3/R5/R9 flush with two failing lines, latency 3
        fill(2, 1);
        lat = 3;
        begin
            int n; logic [31:0] fb; int k;
            k = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (m_valid[s][w] && m_dirty[s][w]) begin
                        if (k == 2 || k == 5) m_err[s][w] = 1'b1;
                        k++;
                    end
            n = 0; fb = '0;
            for (int s = 0; s < SETS && n == 0; s++)
                for (int w = 0; w < WAYS && n == 0; w++)
                    if (m_valid[s][w] && m_dirty[s][w] && m_err[s][w]) begin
                        fb = {m_tag[s][w], SW'(s), {OW{1'b0}}};
                        n = 1;
                    end
            run_flush("errors", 1);
            reg_read(8'h48, rv); check(rv == fb, "R9 first error kept", rv, fb);
            reg_write(8'h48, 32'h1234_5670);
            reg_read(8'h48, rv); check(rv == fb, "R9 nonzero write ignored", rv, fb);
            reg_write(8'h48, 32'h0);
            reg_read(8'h48, rv); check(rv == 0, "R9 zero write clears", rv, 0);
        end

        // R6 invalidate request clears only its own status bit
        reg_write(8'hC0, 32'h4000_0000);
        reg_read(8'hC4, rv);
        check(rv[31] && rv[29] && !rv[30], "R6 inv clears bit30 only", rv, 32'hA000_0000);
        inv_seen = 0;
        wait_clear(32'h4000_0000, "R2 invalidate");
        reg_read(8'hC4, rv); check(rv == 32'hE000_0000, "R7 inv done", rv, 32'hE000_0000);

        // R7 invalidate over a dirty cache: no write-backs, all lines cleared
        fill(3, 1);
        lat = 2;
        reg_write(8'hC0, 32'h4000_0000);
        wait_clear(32'h4000_0000, "R7 invalidate");
        begin
            int bad = 0;
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    if (m_valid[s][w] || m_dirty[s][w]) bad++;
            check(bad == 0, "R7 lines cleared", bad, 0);
        end

        // R6 flush request clears the whole status word at once
        fill(4, 0);
        reg_write(8'hC0, 32'h8000_0000);
        reg_read(8'hC4, rv); check(rv == 0, "R6 flush clears status", rv, 0);
        wait_clear(32'h8000_0000, "R3 empty flush");
        reg_read(8'hC4, rv); check(rv == 32'h8000_0000, "R5 empty flush done", rv, 32'h8000_0000);

        // R8 both requested: flush then invalidate, new error latched
        fill(5, 1);
        lat = 2;
        begin
            int n; logic [31:0] fb;
            for (int s = SETS - 1; s >= 0; s--)
                for (int w = 0; w < WAYS; w++)
                    if (m_valid[s][w] && m_dirty[s][w] && s == SETS - 1) m_err[s][w] = 1'b1;
            push_expected(n, fb);
            inv_seen = 0;
            reg_write(8'hC0, 32'hC000_0000);
            wait_clear(32'hC000_0000, "R8 both");
            check(exp_addr.size() == 0, "R8 flush done first", exp_addr.size(), 0);
            check(inv_seen, "R8 invalidate ran", inv_seen, 1);
            reg_read(8'hC4, rv);
            check(rv == (n > 0 ? 32'hE000_0000 : 32'hC000_0000), "R8 status", rv,
                  n > 0 ? 32'hE000_0000 : 32'hC000_0000);
            reg_read(8'h48, rv); check(rv == fb, "R9 rearmed capture", rv, fb);
        end
        reg_read(8'h4C, rv); check(rv == 0, "R10 idle code", rv, 0);

        finish_run();
    end

endmodule